// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to ten interrupt request sources into a flag register. It qualifies the flags with a per-source enable mask and a global enable. It presents the fixed entry address of the highest-priority pending source to the CPU. Each source owns its own entry address: the first is 003H, and each later one is 3 higher than the one before it. Priority is fixed, and the lowest index wins.

One source is shared with an external interrupt pin. The pin passes through a synchroniser and a digital glitch filter, and then an edge detector whose active edge is selectable. The filter rejects any level that does not stay stable for a programmable number of clocks, 8 by default. It can be switched off when the system runs from a slow low-frequency crystal.

Software sees the flags and the mask at the outputs. It can clear flags through a write port, and it loads the mask through a second write port. Software can never set a flag. Only a request can.

Top module: `irqc_top`

## Requirements
- R1: After reset the flags, the mask, `irq_o` and `vec_o` are all zero.
- R2: A high bit on `req_i` sets the matching flag at the next clock edge, whatever the mask holds. The flag then stays set until software clears it.
- R3: A write on `flag_we_i` makes the flags equal to the old flags AND `flag_wdata_i`. A 0 bit clears its flag and a 1 bit leaves it alone. A write never sets a flag.
- R4: When a request and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: A write on `mask_we_i` loads `mask_wdata_i` into the mask. Without a write the mask keeps its value.
- R6: `vec_o` equals 3 + 3*i, where i is the lowest index whose flag and mask bits are both 1. Source 0 gives 003H and source 9 gives 01EH. `vec_o` is 0 when no such index exists, and it does not depend on `gie_i`.
- R7: `irq_o` is 1 exactly when `gie_i` is 1 and at least one flag is set with its mask bit also set.
- R8: With the filter on (`filt_off_i`=0), the pin sets flag 0 only after the new level has been sampled on 8 consecutive clock edges. The flag becomes set at the 9th edge. A level held for only 7 edges sets nothing.
- R9: `ext_fall_i`=0 selects the rising edge of the pin and `ext_fall_i`=1 selects the falling edge. A filtered transition in the other direction sets no flag.
- R10: With the filter off (`filt_off_i`=1), a pin level sampled at edge 1 sets flag 0 at edge 2, even for a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 10 | Per-source request strobes |
| ext_pin_i | input | 1 | Raw external interrupt pin, OR-ed into source 0 after filtering |
| ext_fall_i | input | 1 | Active-edge select: 0 rising, 1 falling |
| filt_off_i | input | 1 | 1 bypasses the glitch filter |
| gie_i | input | 1 | Global interrupt enable |
| flag_we_i | input | 1 | Flag clear write strobe |
| flag_wdata_i | input | 10 | Flag write data; 0 bits clear |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 10 | Mask write data |
| flag_o | output | 10 | Current flags |
| mask_o | output | 10 | Current mask |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Entry address of the winning source, 0 if none |

## Verification
The bench runs all 1024 request patterns against several mask patterns and both settings of the global enable. Every pattern is set up in a cycle that also carries a clearing write, so a design that lets the clear win over a request would show missing flags everywhere. The expected priority is computed in the bench by scanning from the lowest index. An encoder that favoured high indices, or that used the wrong step, would give wrong addresses. The pin tests look for an off-by-one filter by using 7- and 8-clock pulses. They also check both edge polarities, including the opposite edge that must not set a flag. The bypassed filter must catch a single-cycle pulse one edge after it is sampled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned VEC_BASE = 3;
  localparam int unsigned VEC_STEP = 3;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
endpackage

// File: rtl/irqc_pin_filter.sv
module irqc_pin_filter #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic bypass_i,
  input  logic fall_i,
  output logic event_o
);
  localparam int unsigned CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic             samp_q, lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             differ, take;

  always_comb begin
    differ  = samp_q ^ lvl_q;
    take    = differ & (bypass_i | (cnt_q == CNT_LAST));
    cnt_d   = (differ & ~take) ? cnt_q + 1'b1 : '0;
    lvl_d   = take ? samp_q : lvl_q;
    event_o = take & (samp_q ^ fall_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      samp_q <= pin_i;
      lvl_q  <= lvl_d;
      cnt_q  <= cnt_d;
    end
  end

  // checker-side run length of the sampled pin, saturating
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run_q <= '0;
    else if (samp_q != pin_i)         run_q <= '0;
    else if (run_q != (CNT_W+1)'(FILT_LEN)) run_q <= run_q + 1'b1;
  end

  // R8: a filtered level change needs a stable sampled run of FILT_LEN edges
  p_filter_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bypass_i) && (lvl_q != $past(lvl_q))) |-> ($past(run_q) >= (CNT_W+1)'(FILT_LEN - 1)));

  // R9: an event always matches the selected polarity of the new level
  p_event_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> (lvl_q == ~$past(fall_i)));
endmodule

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
  parameter int unsigned NUM_SRC = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               clr_we_i,
  input  logic [NUM_SRC-1:0] clr_data_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_data_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] flag_q, flag_d, mask_q, mask_d;

  always_comb begin
    flag_d = (clr_we_i ? (flag_q & clr_data_i) : flag_q) | set_i;
    mask_d = mask_we_i ? mask_data_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;

  // R2/R3: a flag rises only where a request was present
  p_flag_rise_by_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0));
  // R4: requests always land, even against a clearing write
  p_req_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  // R5: mask holds without a write
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 10,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [VEC_W-1:0]   vec_o
);
  logic [VEC_W-1:0] vec_tab [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
    assign vec_tab[g] = VEC_W'(VEC_BASE + VEC_STEP * g);
  end

  always_comb begin
    vec_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = vec_tab[i];
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 10,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned FILT_LEN = 8,
  parameter int unsigned EXT_IDX  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               ext_pin_i,
  input  logic               ext_fall_i,
  input  logic               filt_off_i,
  input  logic               gie_i,
  input  logic               flag_we_i,
  input  logic [NUM_SRC-1:0] flag_wdata_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  output logic [NUM_SRC-1:0] flag_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic               ext_evt;
  logic [NUM_SRC-1:0] set_vec, pend;

  irqc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .bypass_i(filt_off_i),
    .fall_i(ext_fall_i), .event_o(ext_evt)
  );

  always_comb begin
    set_vec          = req_i;
    set_vec[EXT_IDX] = req_i[EXT_IDX] | ext_evt;
  end

  irqc_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_we_i(flag_we_i),
    .clr_data_i(flag_wdata_i), .mask_we_i(mask_we_i), .mask_data_i(mask_wdata_i),
    .flag_o(flag_o), .mask_o(mask_o)
  );

  assign pend  = flag_o & mask_o;
  assign irq_o = gie_i & (|pend);

  irqc_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
    .pend_i(pend), .vec_o(vec_o)
  );

  // R7: no request to the CPU while globally disabled
  p_irq_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_i);
  // R6: a zero vector means nothing enabled is pending
  p_vec_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o == '0) |-> ((flag_o & mask_o) == '0));
endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_i = '0, flag_wdata_i = '0, mask_wdata_i = '0;
  logic         ext_pin_i = 1'b0, ext_fall_i = 1'b0, filt_off_i = 1'b0, gie_i = 1'b0;
  logic         flag_we_i = 1'b0, mask_we_i = 1'b0;
  logic [N-1:0] flag_o, mask_o;
  logic         irq_o;
  logic [7:0]   vec_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqc_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ext_pin_i(ext_pin_i),
    .ext_fall_i(ext_fall_i), .filt_off_i(filt_off_i), .gie_i(gie_i),
    .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i), .mask_we_i(mask_we_i),
    .mask_wdata_i(mask_wdata_i), .flag_o(flag_o), .mask_o(mask_o),
    .irq_o(irq_o), .vec_o(vec_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_vec(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return 32'(3 + 3 * i);
    return 32'd0;
  endfunction

  task automatic clear_all();
    flag_we_i = 1'b1; flag_wdata_i = '0;
    @(negedge clk);
    flag_we_i = 1'b0; flag_wdata_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", 32'(flag_o), 0);
    chk("R1 mask", 32'(mask_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 vec", 32'(vec_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: flags set with mask 0, no irq, and held
    for (int i = 0; i < N; i++) begin
      req_i = N'(1) << i; gie_i = 1'b1;
      @(negedge clk);
      req_i = '0;
      repeat (2) @(negedge clk);
      chk("R2 flag set masked", 32'(flag_o), 32'(N'(1) << i));
      chk("R7 masked no irq", 32'(irq_o), 0);
      chk("R6 masked vec", 32'(vec_o), 0);
      clear_all();
    end

    // R3: partial clear and write cannot set
    req_i = 10'h3FF; @(negedge clk); req_i = '0;
    flag_we_i = 1'b1; flag_wdata_i = 10'h155; @(negedge clk); flag_we_i = 1'b0;
    chk("R3 partial clear", 32'(flag_o), 32'h155);
    clear_all();
    flag_we_i = 1'b1; flag_wdata_i = 10'h3FF; @(negedge clk); flag_we_i = 1'b0;
    chk("R3 write no set", 32'(flag_o), 0);

    // R4: request beats clear on the same bit
    req_i = 10'h201; @(negedge clk); req_i = '0;
    req_i = 10'h001; flag_we_i = 1'b1; flag_wdata_i = '0; @(negedge clk);
    req_i = '0; flag_we_i = 1'b0;
    chk("R4 req wins", 32'(flag_o), 32'h001);

    // R5: mask load and hold
    mask_we_i = 1'b1; mask_wdata_i = 10'h2C3; @(negedge clk); mask_we_i = 1'b0;
    mask_wdata_i = 10'h0F0; repeat (2) @(negedge clk);
    chk("R5 mask hold", 32'(mask_o), 32'h2C3);
    clear_all();

    // R6/R7 sweep of all request patterns
    for (int p = 0; p < 1024; p++) begin
      for (int k = 0; k < 2; k++) begin
        logic [N-1:0] m;
        m = (k == 0) ? 10'h3FF : N'((p * 37 + 91) & 1023);
        gie_i = 1'(k ^ (p & 1));
        flag_we_i = 1'b1; flag_wdata_i = '0; req_i = N'(p);
        mask_we_i = 1'b1; mask_wdata_i = m;
        @(negedge clk);
        flag_we_i = 1'b0; req_i = '0; mask_we_i = 1'b0;
        chk("R4 sweep flags", 32'(flag_o), 32'(p));
        chk("R6 sweep vec", 32'(vec_o), exp_vec(N'(p) & m));
        chk("R7 sweep irq", 32'(irq_o), 32'(gie_i & (|(N'(p) & m))));
      end
    end
    clear_all();
    mask_we_i = 1'b1; mask_wdata_i = 10'h3FF; @(negedge clk); mask_we_i = 1'b0;
    gie_i = 1'b1;

    // R8: 7-clock pulse rejected, 8-clock accepted
    ext_fall_i = 1'b0; filt_off_i = 1'b0;
    ext_pin_i = 1'b1; repeat (7) @(negedge clk); ext_pin_i = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 short pulse", 32'(flag_o[0]), 0);
    ext_pin_i = 1'b1; repeat (8) @(negedge clk);
    chk("R8 before 9th edge", 32'(flag_o[0]), 0);
    @(negedge clk);
    chk("R8 at 9th edge", 32'(flag_o[0]), 1);
    chk("R6 ext vec", 32'(vec_o), 3);
    repeat (10) @(negedge clk);
    clear_all();

    // R9: falling edge select, rising ignored
    ext_pin_i = 1'b0; repeat (12) @(negedge clk);
    chk("R9 rise ignored (rise sel, fall seen)", 32'(flag_o[0]), 0);
    ext_fall_i = 1'b1;
    ext_pin_i = 1'b1; repeat (12) @(negedge clk);
    chk("R9 rise ignored in fall mode", 32'(flag_o[0]), 0);
    ext_pin_i = 1'b0; repeat (8) @(negedge clk);
    chk("R9 fall before 9th", 32'(flag_o[0]), 0);
    @(negedge clk);
    chk("R9 fall taken", 32'(flag_o[0]), 1);
    clear_all();

    // R10: bypass catches a one-cycle pulse
    ext_fall_i = 1'b0; filt_off_i = 1'b1;
    ext_pin_i = 1'b1; @(negedge clk); ext_pin_i = 1'b0;
    chk("R10 after edge 1", 32'(flag_o[0]), 0);
    @(negedge clk);
    chk("R10 after edge 2", 32'(flag_o[0]), 1);
    chk("R7 ext irq", 32'(irq_o), 1);

    finish_run();
  end
endmodule